// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between a 32-bit integer pipeline and a 32-bit big-endian data memory port. For each memory operation the pipeline presents a base register value, plus either an index register value or a 13-bit signed immediate. The block adds them to form the effective address and checks that address against the access size. It then issues one memory beat, or two beats for a doubleword.

On loads it picks the addressed byte, halfword or word out of the memory read data. It zero-pads or sign-extends that value and hands it to register writeback with the destination register number. On stores it replicates the source data across the byte lanes and marks the lanes to write with a 4-bit enable mask.

A doubleword moves between memory and an even/odd register pair. The first beat, at the effective address, carries the more significant word and uses the even register. The second beat, at the address plus four, carries the less significant word and uses the odd register. A misaligned address, or a doubleword that names an odd register, raises a one-cycle error pulse, and no memory access takes place.

Top module: `mem_lane_aligner`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended when `req_use_imm` is 1, and `req_base` plus `req_index` when it is 0. `mem_addr` carries the effective address with its two low bits cleared.
- R2: Byte order is big-endian. Byte offset k within a word (effective address bits 1:0) maps to lane 3-k. Lane i is `mem_rdata`/`mem_wdata` bits 8i+7:8i and is enabled by `mem_be[i]`. Offset 0 is therefore bits 31:24.
- R3: A byte load (`req_size`=0) with `req_signed`=0 returns the selected byte zero-padded. With `req_signed`=1 it returns the byte sign-extended from its bit 7.
- R4: A halfword load (`req_size`=1) returns bits 31:16 at offset 0 and bits 15:0 at offset 2. It zero-pads when `req_signed`=0 and sign-extends from bit 15 when `req_signed`=1.
- R5: A byte store drives the low byte of `req_src` on all four lanes and enables only the addressed lane. A halfword store drives the low half of `req_src` on both halves, with `mem_be`=1100 at offset 0 and 0011 at offset 2. A word store (`req_size`=2) drives `req_src` with `mem_be`=1111.
- R6: A halfword needs address bit 0 clear, a word needs bits 1:0 clear, and a doubleword needs bits 2:0 clear. A violation makes `err` high for exactly the cycle after the request, with no `mem_req` and no `wb_valid`.
- R7: A doubleword (`req_size`=3) whose `req_reg` is odd is rejected in the same way as R6.
- R8: A doubleword runs two beats in consecutive cycles. The first beat is at the aligned address, uses register `req_reg` and data `req_src`, and carries the more significant word. The second beat is at that address plus 4, uses register `req_reg`+1 and data `req_src_odd`, and carries the less significant word. `mem_be`=1111 on both beats, and `busy` stays high through both.
- R9: A request is taken when `req_valid` is high and `busy` is low, and its first beat appears in the next cycle. `mem_we` is 1 for stores and 0 for loads. For loads, `wb_valid`, `wb_reg` and `wb_data` follow `mem_rdata` in the same beat cycle. A request presented while `busy` is high is ignored.
- R10: Word and doubleword loads return the full 32-bit read word whatever `req_signed` is.
- R11: During reset, `mem_req`, `busy`, `err` and `wb_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_load | input | 1 | 1 for a load, 0 for a store |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_base | input | ADDR_W | Base register value |
| req_index | input | ADDR_W | Index register value |
| req_imm | input | IMM_W | Signed immediate offset |
| req_use_imm | input | 1 | Select the immediate as the offset |
| req_reg | input | RADDR_W | Destination (load) or source (store) register number |
| req_src | input | 32 | Store data; the even register for a doubleword |
| req_src_odd | input | 32 | Odd register value for a doubleword store |
| busy | output | 1 | A memory beat is in progress |
| err | output | 1 | One-cycle misalignment or odd-pair error |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Replicated write data |
| mem_rdata | input | 32 | Memory read data, valid in the beat cycle |
| wb_valid | output | 1 | Load writeback valid |
| wb_reg | output | RADDR_W | Writeback register number |
| wb_data | output | 32 | Extended load data |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 13-bit immediate and 5-bit register numbers. It sweeps every access size over all eight byte offsets of a doubleword, in both directions and with both sign settings. This reaches every lane, every misalignment case and both even and odd pair registers. The immediate path gets both positive and negative offsets. The memory model computes each word from its address, so the bench can derive every expected lane and extension arithmetically. One sweep step also presents a second request during a doubleword to show that it is dropped.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BEAT0 = 2'b01,
    ST_BEAT1 = 2'b10
  } beat_state_e;
endpackage

// File: rtl/lsa_rst_sync.sv
module lsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lsa_agen.sv
module lsa_agen
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 13
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  acc_size_e         size_i,
  input  logic              reg_lsb_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              fault_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = use_imm_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : index_i;
    ea_o   = base_i + offset;
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  fault_o = 1'b0;
      SZ_HALF:  fault_o = ea_o[0];
      SZ_WORD:  fault_o = |ea_o[1:0];
      default:  fault_o = (|ea_o[2:0]) | reg_lsb_i;
    endcase
  end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [1:0]        ofs_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam int unsigned HALVES = LANES / 2;

  logic [WORD_W-1:0] byte_rep;
  logic [WORD_W-1:0] half_rep;

  for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
    assign byte_rep[8*g +: 8] = src_i[7:0];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half_rep
    assign half_rep[16*g +: 16] = src_i[15:0];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o    = LANES'(1) << (~ofs_i);
        wdata_o = byte_rep;
      end
      SZ_HALF: begin
        be_o    = ofs_i[1] ? 4'b0011 : 4'b1100;
        wdata_o = half_rep;
      end
      default: begin
        be_o    = '1;
        wdata_o = src_i;
      end
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [1:0]        ofs_i,
  input  logic              signed_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] data_o
);
  logic [7:0]  lane [LANES];
  logic [7:0]  bsel;
  logic [15:0] hsel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rdata_i[8*g +: 8];
  end

  always_comb begin
    bsel = lane[~ofs_i];
    hsel = ofs_i[1] ? rdata_i[15:0] : rdata_i[31:16];
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){signed_i & bsel[7]}}, bsel};
      SZ_HALF: data_o = {{(WORD_W-16){signed_i & hsel[15]}}, hsel};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IMM_W   = 13,
  parameter int unsigned RADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_load,
  input  logic [1:0]         req_size,
  input  logic               req_signed,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [ADDR_W-1:0]  req_index,
  input  logic [IMM_W-1:0]   req_imm,
  input  logic               req_use_imm,
  input  logic [RADDR_W-1:0] req_reg,
  input  logic [31:0]        req_src,
  input  logic [31:0]        req_src_odd,
  output logic               busy,
  output logic               err,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               wb_valid,
  output logic [RADDR_W-1:0] wb_reg,
  output logic [31:0]        wb_data
);
  localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(LANES);

  logic rst_sync_n;

  lsa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic              fault;

  assign size_in = acc_size_e'(req_size);

  lsa_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .base_i    (req_base),
    .index_i   (req_index),
    .imm_i     (req_imm),
    .use_imm_i (req_use_imm),
    .size_i    (size_in),
    .reg_lsb_i (req_reg[0]),
    .ea_o      (ea),
    .fault_o   (fault)
  );

  beat_state_e       st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  acc_size_e         size_q;
  logic              sgn_q, load_q, err_q, err_d;
  logic [RADDR_W-1:0] reg_q;
  logic [1:0]        ofs_q;
  logic [31:0]       src_q, src_odd_q;
  logic              accept, cap_en, in_beat1;

  always_comb begin
    accept = req_valid && (st_q == ST_IDLE);
    cap_en = accept && !fault;
    err_d  = accept && fault;
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE:  if (cap_en) st_d = ST_BEAT0;
      ST_BEAT0: st_d = (size_q == SZ_DWORD) ? ST_BEAT1 : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q    <= '0;
      size_q    <= SZ_BYTE;
      sgn_q     <= 1'b0;
      load_q    <= 1'b0;
      reg_q     <= '0;
      ofs_q     <= '0;
      src_q     <= '0;
      src_odd_q <= '0;
    end else if (cap_en) begin
      addr_q    <= {ea[ADDR_W-1:2], 2'b00};
      size_q    <= size_in;
      sgn_q     <= req_signed;
      load_q    <= req_load;
      reg_q     <= req_reg;
      ofs_q     <= ea[1:0];
      src_q     <= req_src;
      src_odd_q <= req_src_odd;
    end
  end

  assign in_beat1 = (st_q == ST_BEAT1);

  lsa_store_steer u_steer (
    .size_i  (size_q),
    .ofs_i   (ofs_q),
    .src_i   (in_beat1 ? src_odd_q : src_q),
    .be_o    (mem_be),
    .wdata_o (mem_wdata)
  );

  lsa_load_extract u_extract (
    .size_i   (size_q),
    .ofs_i    (ofs_q),
    .signed_i (sgn_q),
    .rdata_i  (mem_rdata),
    .data_o   (wb_data)
  );

  assign mem_req  = (st_q != ST_IDLE);
  assign busy     = mem_req;
  assign err      = err_q;
  assign mem_we   = mem_req && !load_q;
  assign mem_addr = in_beat1 ? addr_q + BEAT_STEP : addr_q;
  assign wb_valid = mem_req && load_q;
  assign wb_reg   = in_beat1 ? {reg_q[RADDR_W-1:1], 1'b1} : reg_q;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned RADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               err,
  input logic               mem_req,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [3:0]         mem_be,
  input logic               wb_valid,
  input logic [RADDR_W-1:0] wb_reg,
  input logic [31:0]        wb_data,
  input logic [1:0]         st_q,
  input logic [1:0]         size_q,
  input logic               sgn_q
);
  // R6 R7: a rejected access never reaches memory
  assert_err_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req);

  // R8: second beat follows the first at the next word address
  assert_beat1_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'b10) |-> ($past(mem_req) && mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R8: second beat writes back the odd partner register
  assert_beat1_odd_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'b10 && wb_valid) |-> (wb_reg[0] && wb_reg == ($past(wb_reg) | RADDR_W'(1))));

  // R2 R5: a byte access touches exactly one lane
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size_q == 2'b00) |-> ($countones(mem_be) == 1));

  // R3: unsigned byte loads carry no upper bits
  assert_ubyte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && size_q == 2'b00 && !sgn_q) |-> (wb_data[31:8] == 24'h0));

  // R9: writeback only for loads
  assert_wb_not_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !mem_we);
endmodule

bind mem_lane_aligner lsa_checker #(.ADDR_W(ADDR_W), .RADDR_W(RADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .err      (err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .wb_valid (wb_valid),
  .wb_reg   (wb_reg),
  .wb_data  (wb_data),
  .st_q     (st_q),
  .size_q   (size_q),
  .sgn_q    (sgn_q)
);

// File: tb/sim_mem_lane_aligner.sv
module sim_mem_lane_aligner;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_load, req_signed, req_use_imm;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_index, req_src, req_src_odd;
  logic [12:0] req_imm;
  logic [4:0]  req_reg;
  logic        busy, err, mem_req, mem_we, wb_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_data;
  logic [3:0]  mem_be;
  logic [4:0]  wb_reg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A0F_C3A5;
  endfunction

  assign mem_rdata = memf(mem_addr);

  mem_lane_aligner u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
    .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
    .req_index(req_index), .req_imm(req_imm), .req_use_imm(req_use_imm),
    .req_reg(req_reg), .req_src(req_src), .req_src_odd(req_src_odd),
    .busy(busy), .err(err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic check_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input int n, input int sz, input int off, input bit ld, input bit sg);
    logic [31:0] ea, wa, w, simm, src, src2, exp_d, exp_wd;
    logic [12:0] imm;
    logic [7:0]  b;
    logic [15:0] h;
    logic [4:0]  rd;
    logic [3:0]  exp_be;
    bit fault;
    ea   = 32'h0000_4000 + 32'(n) * 16 + 32'(off);
    wa   = {ea[31:2], 2'b00};
    rd   = 5'(n);
    imm  = 13'(n * 613 + 4000);
    simm = {{19{imm[12]}}, imm};
    src  = 32'h80FF_7F01 ^ (32'(n) * 32'h1357_9BDF);
    src2 = ~src ^ 32'(n);
    fault = (sz == 1 && ea[0]) || (sz == 2 && ea[1:0] != 0) ||
            (sz == 3 && (ea[2:0] != 0 || rd[0]));

    @(negedge clk);
    req_valid   = 1'b1;
    req_load    = ld;
    req_size    = 2'(sz);
    req_signed  = sg;
    req_reg     = rd;
    req_src     = src;
    req_src_odd = src2;
    req_use_imm = n[0];
    req_imm     = imm;
    req_index   = 32'h300 + 32'(n) * 7;
    req_base    = n[0] ? ea - simm : ea - req_index;

    @(negedge clk);
    if (sz == 3 && !fault) begin
      req_base = req_base + 32'h100;   // R9: must be ignored while busy
      req_load = ~ld;
    end else begin
      req_valid = 1'b0;
    end

    if (fault) begin
      check_eq(sz == 3 ? "R7 err" : "R6 err", 32'(err), 1);
      check_eq("R6 no mem_req", 32'(mem_req), 0);
      check_eq("R6 no wb_valid", 32'(wb_valid), 0);
    end else begin
      w = memf(wa);
      check_eq("R6 no err", 32'(err), 0);
      check_eq("R9 mem_req", 32'(mem_req), 1);
      check_eq("R1 mem_addr", mem_addr, wa);
      check_eq("R9 mem_we", 32'(mem_we), 32'(!ld));
      if (sz == 3) check_eq("R8 busy beat0", 32'(busy), 1);
      if (ld) begin
        b = 8'(w >> (8 * (3 - off % 4)));
        h = ea[1] ? w[15:0] : w[31:16];
        case (sz)
          0: exp_d = sg ? {{24{b[7]}}, b} : {24'h0, b};
          1: exp_d = sg ? {{16{h[15]}}, h} : {16'h0, h};
          default: exp_d = w;
        endcase
        check_eq("R9 wb_valid", 32'(wb_valid), 1);
        check_eq("R9 wb_reg", 32'(wb_reg), 32'(rd));
        check_eq(sz == 0 ? "R3 byte load" : sz == 1 ? "R4 half load" : "R10 word load",
                 wb_data, exp_d);
      end else begin
        case (sz)
          0: begin exp_be = 4'b0001 << (3 - off % 4); exp_wd = {4{src[7:0]}}; end
          1: begin exp_be = ea[1] ? 4'b0011 : 4'b1100; exp_wd = {2{src[15:0]}}; end
          default: begin exp_be = 4'b1111; exp_wd = src; end
        endcase
        check_eq("R2 mem_be", 32'(mem_be), 32'(exp_be));
        check_eq("R5 mem_wdata", mem_wdata, exp_wd);
      end
    end

    if (sz == 3 && !fault) begin
      @(negedge clk);
      req_valid = 1'b0;
      check_eq("R8 beat1 mem_req", 32'(mem_req), 1);
      check_eq("R8 busy beat1", 32'(busy), 1);
      check_eq("R8 beat1 addr", mem_addr, wa + 4);
      check_eq("R8 beat1 mem_we", 32'(mem_we), 32'(!ld));
      if (ld) begin
        check_eq("R8 beat1 wb_reg", 32'(wb_reg), 32'(rd | 5'd1));
        check_eq("R8 beat1 data", wb_data, memf(wa + 4));
      end else begin
        check_eq("R8 beat1 be", 32'(mem_be), 32'hF);
        check_eq("R8 beat1 wdata", mem_wdata, src2);
      end
    end

    @(negedge clk);
    check_eq("R9 idle after op", 32'(mem_req), 0);
    check_eq("R6 err one cycle", 32'(err), 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    req_valid = 0; req_load = 0; req_size = 0; req_signed = 0; req_use_imm = 0;
    req_base = 0; req_index = 0; req_imm = 0; req_reg = 0; req_src = 0; req_src_odd = 0;
    repeat (3) @(negedge clk);
    check_eq("R11 mem_req", 32'(mem_req), 0);
    check_eq("R11 busy", 32'(busy), 0);
    check_eq("R11 err", 32'(err), 0);
    check_eq("R11 wb_valid", 32'(wb_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 8; off++)
        for (int ld = 0; ld < 2; ld++)
          for (int sg = 0; sg < 2; sg++) begin
            run_op(n, sz, off, ld[0], sg[0]);
            n++;
          end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule